// File: doc/BRIEF.md
# Iterative Half-Adder Recursive Adder

This block adds two unsigned N-bit operands by repeating parallel half-additions until no carry is left in flight. On an accepted start request, every bit lane half-adds its two operand bits in the same clock step. In every later step, each lane half-adds its stored sum bit with the carry held by the lane just below it. Lane 0 always sees a zero carry.

The lanes go on stepping, one clock per step, until all lane carries are zero. At that point the completion flag rises, and the sum and carry-out are final. Latency therefore depends on the data. Operands that create no carries finish after the single load step. The longest carry chain needs about N further steps.

A two-input select in every lane picks the operand bits on the load step and the feedback path on every later step. The carry leaving the top lane is not fed back. It is gathered into a sticky carry-out bit.

Top module: `rha_adder`

## Requirements
- R1: When start_i is sampled high while the block is not busy, every lane i loads sum = a_i[i] XOR b_i[i] and carry = a_i[i] AND b_i[i]. From the next step on, every lane takes its inputs from the feedback path.
- R2: On each feedback step, lane i computes new sum = sum XOR cin and new carry = sum AND cin. Here cin is the stored carry of lane i-1, and cin is 0 for lane 0. A lane that holds carry 1 holds carry 0 after the next step.
- R3: No lane ever holds carry = 1 and sum = 1 at the same time.
- R4: done_o is high exactly when the feedback phase is active and all lane carries are zero. It is 0 after reset and before the first start, whatever the operands are.
- R5: If the operand bits produce no carry in any lane, done_o is high right after the load step, one clock edge after start is accepted.
- R6: While done_o is high, {cout_o, sum_o} equals a_i + b_i as captured at the accepted start.
- R7: cout_o is the OR of every carry the top lane held during the operation. It is cleared on each accepted start.
- R8: From the accepted start to done_o, at most N+1 clock edges pass. All-ones plus one takes exactly N+1.
- R9: While done_o is high and no new start arrives, done_o, sum_o and cout_o hold their values.
- R10: A start_i pulse while busy_o is high is ignored. The running result and its latency are unchanged.
- R11: After synchronous reset, done_o, busy_o, sum_o and cout_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to load new operands |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| sum_o | output | WIDTH | Sum bits held by the lanes |
| cout_o | output | 1 | Sticky carry-out of the top lane |
| done_o | output | 1 | Completion: feedback phase with no carry left |
| busy_o | output | 1 | Feedback phase with carries still moving |

## Verification
The main pattern is an exhaustive sweep of every operand pair of a 6-bit instance, each checked against the arithmetic sum. This separates faults in the lane half-add, the lane-0 carry input and the sticky carry-out. Zero plus zero and operand pairs with disjoint bits show whether completion waits for the feedback select but no longer. All-ones plus one shows the full carry walk and pins the latency at N+1. A start pulse injected mid-walk, and extra cycles spent in the done state, tell a correct guard and hold apart from restarts or drifting outputs.

// File: rtl/rha_pkg.sv
package rha_pkg;

    typedef struct packed {
        logic carry;
        logic sum;
    } lane_st_t;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_ITER = 1'b1
    } phase_t;

    function automatic lane_st_t half_add(input logic x, input logic y);
        lane_st_t r;
        r.sum   = x ^ y;
        r.carry = x & y;
        return r;
    endfunction

endpackage

// File: rtl/rha_lane.sv
module rha_lane
    import rha_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  logic     step,
    input  logic     op_a,
    input  logic     op_b,
    input  logic     carry_in,
    output lane_st_t st
);

    logic x_sel, y_sel;

    // two-input select: operands on load, feedback otherwise
    always_comb begin
        if (load) begin
            x_sel = op_a;
            y_sel = op_b;
        end else begin
            x_sel = st.sum;
            y_sel = carry_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            st <= '0;
        else if (load || step)
            st <= half_add(x_sel, y_sel);
    end

    // R3: half-add outputs are exclusive
    a_r3_no_pair11: assert property (@(posedge clk) disable iff (rst)
        !(st.carry && st.sum));

    // R2: a held carry leaves the lane on the next feedback step
    a_r2_carry_leaves: assert property (@(posedge clk) disable iff (rst)
        (step && !load && st.carry) |=> !st.carry);

endmodule

// File: rtl/rha_finish.sv
module rha_finish #(
    parameter int WIDTH = 16
) (
    input  logic             sel,
    input  logic [WIDTH-1:0] carries,
    output logic             done
);

    assign done = sel & ~(|carries);

endmodule

// File: rtl/rha_adder.sv
module rha_adder
    import rha_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o,
    output logic             done_o,
    output logic             busy_o
);

    localparam int CNT_W   = $clog2(WIDTH + 2) + 1;
    localparam int CNT_MAX = (1 << CNT_W) - 1;

    phase_t           phase;
    logic             sel;
    logic             load;
    logic             step;
    logic             cout_q;
    logic [WIDTH-1:0] carry_v;
    logic [WIDTH-1:0] sum_v;

    assign sel    = (phase == PH_ITER);
    assign busy_o = sel & ~done_o;
    assign load   = start_i & ~busy_o;
    assign step   = busy_o;

    for (genvar i = 0; i < WIDTH; i++) begin : g_lane
        lane_st_t st;
        logic     cin;
        if (i == 0) begin : g_low
            assign cin = 1'b0;
        end else begin : g_up
            assign cin = carry_v[i-1];
        end
        rha_lane u_lane (
            .clk      (clk),
            .rst      (rst),
            .load     (load),
            .step     (step),
            .op_a     (a_i[i]),
            .op_b     (b_i[i]),
            .carry_in (cin),
            .st       (st)
        );
        assign carry_v[i] = st.carry;
        assign sum_v[i]   = st.sum;
    end

    rha_finish #(.WIDTH(WIDTH)) u_finish (
        .sel     (sel),
        .carries (carry_v),
        .done    (done_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            cout_q <= 1'b0;
        end else if (load) begin
            phase  <= PH_ITER;
            cout_q <= 1'b0;
        end else if (step) begin
            cout_q <= cout_q | carry_v[WIDTH-1];
        end
    end

    assign sum_o  = sum_v;
    assign cout_o = cout_q;

    // step counter used only by the checks below
    logic [CNT_W-1:0] iter_cnt;
    always_ff @(posedge clk) begin
        if (rst)
            iter_cnt <= '0;
        else if (load)
            iter_cnt <= CNT_W'(1);
        else if (step && iter_cnt != CNT_W'(CNT_MAX))
            iter_cnt <= iter_cnt + 1'b1;
    end

    // R4: completion only in feedback phase with no carry left
    a_r4_done_clear: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (sel && carry_v == '0));

    a_r4_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !sel |-> !done_o);

    // R8: bounded number of steps
    a_r8_bound: assert property (@(posedge clk) disable iff (rst)
        sel |-> (int'(iter_cnt) <= WIDTH + 1));

    // R9: result holds while complete
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> (done_o && $stable(sum_o) && $stable(cout_o)));

    // R10: a start while busy does not restart the count
    a_r10_no_restart: assert property (@(posedge clk) disable iff (rst)
        (busy_o && iter_cnt != CNT_W'(CNT_MAX)) |=> (iter_cnt == $past(iter_cnt) + 1'b1));

    // R7: once the top carry is gathered it never returns
    a_r7_top_once: assert property (@(posedge clk) disable iff (rst)
        (busy_o && cout_q) |-> !carry_v[WIDTH-1]);

endmodule

// File: tb/sim_rha_adder.sv
`timescale 1ns/1ps
module sim_rha_adder;

    localparam int W          = 6;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst;
    logic         start;
    logic [W-1:0] a, b;
    logic [W-1:0] sum;
    logic         cout, done, busy;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rha_adder #(.WIDTH(W)) u0 (
        .clk     (clk),
        .rst     (rst),
        .start_i (start),
        .a_i     (a),
        .b_i     (b),
        .sum_o   (sum),
        .cout_o  (cout),
        .done_o  (done),
        .busy_o  (busy)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic run_add(input logic [W-1:0] x, input logic [W-1:0] y,
                           output int steps, output logic [W:0] res);
        @(negedge clk);
        a = x; b = y; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        steps = 1;
        while (!done && steps < 4 * W) begin
            @(negedge clk);
            steps++;
        end
        res = {cout, sum};
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        total++;
        bad++;
        $display("FAIL watchdog actual=0 expected=1");
        summary();
    end

    initial begin
        int steps;
        logic [W:0] res;
        logic [W:0] held;
        logic [W-1:0] ones;
        int worst;
        ones = '1;
        rst = 1'b1; start = 1'b0; a = '0; b = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        check(!done && !busy && sum == '0 && !cout, "R11 reset outputs",
              {done, busy, cout, sum}, 0);

        // R4 no completion before any start, even with carry-free operands
        a = '0; b = '0;
        repeat (3) @(negedge clk);
        check(!done, "R4 idle done", done, 0);

        // R5 zero plus zero completes after the load step
        run_add('0, '0, steps, res);
        check(steps == 1, "R5 latency 0+0", steps, 1);
        check(res == 0, "R6 0+0", res, 0);

        // R5 disjoint bits: no carries at load
        run_add(6'b101010, 6'b010101, steps, res);
        check(steps == 1, "R5 latency disjoint", steps, 1);
        check(res == 63, "R1 disjoint sum", res, 63);

        // R2 single carry from lane 0 moves one lane up
        run_add(6'd1, 6'd1, steps, res);
        check(steps == 2, "R2 latency 1+1", steps, 2);
        check(res == 2, "R2 1+1", res, 2);

        // R8 worst chain all-ones plus one
        run_add(ones, 6'd1, steps, res);
        check(steps == W + 1, "R8 latency ones+1", steps, W + 1);
        check(res == (1 << W), "R7 ones+1 carry-out", res, 1 << W);

        // R9 hold while done
        held = {cout, sum};
        a = 6'd17; b = 6'd9;
        repeat (4) @(negedge clk);
        check(done && {cout, sum} == held, "R9 hold", {cout, sum}, held);

        // R10 start during busy ignored
        @(negedge clk);
        a = ones; b = 6'd1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        a = '0; b = '0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        steps = 3;
        while (!done && steps < 4 * W) begin
            @(negedge clk);
            steps++;
        end
        check(steps == W + 1, "R10 latency unchanged", steps, W + 1);
        check({cout, sum} == (1 << W), "R10 result unchanged", {cout, sum}, 1 << W);

        // R6 R3 R7 exhaustive sweep
        worst = 0;
        for (int i = 0; i < (1 << W); i++) begin
            for (int j = 0; j < (1 << W); j++) begin
                run_add(W'(i), W'(j), steps, res);
                if (steps > worst) worst = steps;
                check(done && int'(res) == i + j, "R6 R3 sweep sum", res, i + j);
                if (cout != ((i + j) >= (1 << W)))
                    check(1'b0, "R7 sweep carry-out", cout, (i + j) >> W);
            end
        end
        check(worst <= W + 1, "R8 sweep bound", worst, W + 1);

        // R11 reset after activity
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(!done && !busy && sum == '0 && !cout, "R11 second reset",
              {done, busy, cout, sum}, 0);

        summary();
    end

endmodule